// File: doc/BRIEF.md
# Four-Function Arithmetic and Logic Unit

This block is a purely combinational arithmetic and logic unit of parameterised width. Two operands and a two-bit operation code come in; a result of the same width, a carry-out flag and a signed overflow flag go out, all valid within the same cycle. It is meant to sit in a datapath between an operand register stage and a writeback stage, with no state of its own.

The add path is a ripple chain of one-bit full-adder cells. Subtraction reuses that same chain. Each bit of the second operand passes through an XOR gate driven by a subtract control, which inverts it when the control is set. The same control feeds the lowest carry-in, so the chain adds the two's complement of the second operand. Signed overflow is taken from the disagreement between the carry entering the top cell and the carry leaving it. A final multiplexer picks the bitwise or arithmetic result named by the operation code.

Top module: `alu_quad`

## Requirements
- R1: With `op_i` = 2'b00 the result equals the bitwise AND of the two operands.
- R2: With `op_i` = 2'b01 the result equals the bitwise OR of the two operands.
- R3: With `op_i` = 2'b10 the result is `a_i + b_i` modulo 2^W, and `cout_o` is bit W of the unsigned (W+1)-bit sum.
- R4: With `op_i` = 2'b11 the result is `a_i - b_i` modulo 2^W, and `cout_o` is 1 exactly when `a_i >= b_i` as unsigned values (no borrow).
- R5: For an add, `ovf_o` is 1 exactly when both operands share a sign bit and the result's sign bit differs from it (two positives giving a negative, or two negatives giving a non-negative).
- R6: For a subtract, `ovf_o` is 1 exactly when the operands' sign bits differ and the result's sign bit differs from that of `a_i`.
- R7: For the two bitwise operations, `cout_o` and `ovf_o` are both 0.
- R8: The outputs depend only on the present inputs: the same input vector gives the same outputs whatever vectors came before.
- R9: The behaviour of R1 to R7 holds for every width W of 2 or more, including the corner values at W = 4 over all operand pairs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | W | First operand |
| b_i | input | W | Second operand (subtrahend for a subtract) |
| op_i | input | 2 | Operation: 00 AND, 01 OR, 10 add, 11 subtract |
| res_o | output | W | Selected result |
| cout_o | output | 1 | Carry out of the top adder cell; 0 for bitwise operations |
| ovf_o | output | 1 | Two's-complement overflow; 0 for bitwise operations |

## Verification
The block holds no state, so any internal fault shows at the ports in the very cycle its input vector is applied: a broken carry link corrupts the result bits above it and usually the carry-out, a missing XOR inversion or carry-in turns a subtract into an add or an off-by-one, and a wrong top-carry tap flips the overflow flag on the sign-boundary vectors. The bench therefore aims at those vectors directly (largest positive plus one, most negative minus one, all-ones plus one, zero minus one) and sweeps every operand pair and operation at a four-bit width, where every carry pattern occurs.

// File: rtl/alu_quad_pkg.sv
package alu_quad_pkg;

    typedef enum logic [1:0] {
        OP_AND = 2'b00,
        OP_OR  = 2'b01,
        OP_ADD = 2'b10,
        OP_SUB = 2'b11
    } alu_op_e;

endpackage

// File: rtl/fa_cell.sv
module fa_cell (
    input  logic x_i,
    input  logic y_i,
    input  logic ci_i,
    output logic s_o,
    output logic co_o
);
    logic half_d;

    always_comb begin
        half_d = x_i ^ y_i;
        s_o    = half_d ^ ci_i;
        co_o   = (x_i & y_i) | (half_d & ci_i);
    end
endmodule

// File: rtl/addsub_chain.sv
module addsub_chain #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o,
    output logic         c_top_in_o,
    output logic         c_out_o
);
    localparam int TOP = W - 1;

    logic [W:0]   carry_d;
    logic [W-1:0] b_eff_d;

    assign carry_d[0] = sub_i;

    generate
        for (genvar k = 0; k < W; k++) begin : g_cell
            assign b_eff_d[k] = b_i[k] ^ sub_i;
            fa_cell u_fa (
                .x_i  (a_i[k]),
                .y_i  (b_eff_d[k]),
                .ci_i (carry_d[k]),
                .s_o  (sum_o[k]),
                .co_o (carry_d[k+1])
            );
        end
    endgenerate

    assign c_top_in_o = carry_d[TOP];
    assign c_out_o    = carry_d[W];
endmodule

// File: rtl/bitwise_unit.sv
module bitwise_unit #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] and_o,
    output logic [W-1:0] or_o
);
    always_comb begin
        and_o = a_i & b_i;
        or_o  = a_i | b_i;
    end
endmodule

// File: rtl/result_mux.sv
module result_mux
    import alu_quad_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_op_e      op_i,
    input  logic [W-1:0] and_i,
    input  logic [W-1:0] or_i,
    input  logic [W-1:0] sum_i,
    input  logic         c_top_in_i,
    input  logic         c_out_i,
    output logic [W-1:0] res_o,
    output logic         cout_o,
    output logic         ovf_o
);
    typedef struct packed {
        logic [W-1:0] res;
        logic         cout;
        logic         ovf;
    } sel_t;

    sel_t sel_d;

    always_comb begin
        sel_d = '0;
        unique case (op_i)
            OP_AND: sel_d.res = and_i;
            OP_OR:  sel_d.res = or_i;
            default: begin
                sel_d.res  = sum_i;
                sel_d.cout = c_out_i;
                sel_d.ovf  = c_top_in_i ^ c_out_i;
            end
        endcase
    end

    assign res_o  = sel_d.res;
    assign cout_o = sel_d.cout;
    assign ovf_o  = sel_d.ovf;
endmodule

// File: rtl/alu_quad.sv
module alu_quad
    import alu_quad_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [1:0]   op_i,
    output logic [W-1:0] res_o,
    output logic         cout_o,
    output logic         ovf_o
);
    alu_op_e      op_d;
    logic         sub_d;
    logic [W-1:0] and_d;
    logic [W-1:0] or_d;
    logic [W-1:0] sum_d;
    logic         c_top_in_d;
    logic         c_out_d;

    always_comb begin
        op_d  = alu_op_e'(op_i);
        sub_d = (op_d == OP_SUB);
    end

    addsub_chain #(.W(W)) u_chain (
        .a_i        (a_i),
        .b_i        (b_i),
        .sub_i      (sub_d),
        .sum_o      (sum_d),
        .c_top_in_o (c_top_in_d),
        .c_out_o    (c_out_d)
    );

    bitwise_unit #(.W(W)) u_logic (
        .a_i   (a_i),
        .b_i   (b_i),
        .and_o (and_d),
        .or_o  (or_d)
    );

    result_mux #(.W(W)) u_mux (
        .op_i       (op_d),
        .and_i      (and_d),
        .or_i       (or_d),
        .sum_i      (sum_d),
        .c_top_in_i (c_top_in_d),
        .c_out_i    (c_out_d),
        .res_o      (res_o),
        .cout_o     (cout_o),
        .ovf_o      (ovf_o)
    );
endmodule

// File: rtl/alu_quad_chk.sv
module alu_quad_chk #(
    parameter int W = 32
) (
    input logic [W-1:0] a_i,
    input logic [W-1:0] b_i,
    input logic [1:0]   op_i,
    input logic [W-1:0] res_o,
    input logic         cout_o,
    input logic         ovf_o
);
    localparam int MSB = W - 1;

    logic [W:0] wide_sum;
    logic [W:0] wide_diff;

    always_comb begin
        wide_sum  = {1'b0, a_i} + {1'b0, b_i};
        wide_diff = {1'b0, a_i} - {1'b0, b_i};
        if (op_i == 2'b00) begin
            assert_and_result_R1: assert (res_o == (a_i & b_i))
                else $error("R1 AND result wrong");
        end
        if (op_i == 2'b01) begin
            assert_or_result_R2: assert (res_o == (a_i | b_i))
                else $error("R2 OR result wrong");
        end
        if (op_i[1] == 1'b0) begin
            assert_logic_flags_zero_R7: assert (!cout_o && !ovf_o)
                else $error("R7 flags set on bitwise op");
        end
        if (op_i == 2'b10) begin
            assert_add_sum_R3: assert ({cout_o, res_o} == wide_sum)
                else $error("R3 add sum or carry wrong");
            assert_add_overflow_R5: assert (ovf_o ==
                ((a_i[MSB] == b_i[MSB]) && (res_o[MSB] != a_i[MSB])))
                else $error("R5 add overflow wrong");
        end
        if (op_i == 2'b11) begin
            assert_sub_diff_R4: assert ((res_o == wide_diff[MSB:0]) &&
                (cout_o == (a_i >= b_i)))
                else $error("R4 subtract result or carry wrong");
            assert_sub_overflow_R6: assert (ovf_o ==
                ((a_i[MSB] != b_i[MSB]) && (res_o[MSB] != a_i[MSB])))
                else $error("R6 subtract overflow wrong");
        end
    end
endmodule

bind alu_quad alu_quad_chk #(.W(W)) u_alu_quad_chk (
    .a_i    (a_i),
    .b_i    (b_i),
    .op_i   (op_i),
    .res_o  (res_o),
    .cout_o (cout_o),
    .ovf_o  (ovf_o)
);

// File: tb/test_alu_quad.sv
`timescale 1ns/1ps
module test_alu_quad;
    localparam int WW = 32;
    localparam int WN = 4;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic [WW-1:0] a_w, b_w, res_w;
    logic [1:0]    op_w;
    logic          cout_w, ovf_w;

    logic [WN-1:0] a_n, b_n, res_n;
    logic [1:0]    op_n;
    logic          cout_n, ovf_n;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    alu_quad #(.W(WW)) i_alu_quad (
        .a_i(a_w), .b_i(b_w), .op_i(op_w),
        .res_o(res_w), .cout_o(cout_w), .ovf_o(ovf_w)
    );

    alu_quad #(.W(WN)) i_alu_quad_narrow (
        .a_i(a_n), .b_i(b_n), .op_i(op_n),
        .res_o(res_n), .cout_o(cout_n), .ovf_o(ovf_n)
    );

    function automatic longint to_signed(longint x, int w);
        if (x[w-1]) return x - (longint'(1) << w);
        return x;
    endfunction

    task automatic model(input longint a, input longint b, input int op, input int w,
                         output longint res, output longint cy, output longint ov);
        longint mask = (longint'(1) << w) - 1;
        longint smax = (longint'(1) << (w-1)) - 1;
        longint smin = -(longint'(1) << (w-1));
        longint sr;
        res = 0; cy = 0; ov = 0;
        case (op)
            0: res = a & b;
            1: res = a | b;
            2: begin
                res = (a + b) & mask;
                cy  = ((a + b) >> w) & 1;
                sr  = to_signed(a, w) + to_signed(b, w);
                ov  = (sr > smax || sr < smin) ? 1 : 0;
            end
            default: begin
                res = (a - b) & mask;
                cy  = (a >= b) ? 1 : 0;
                sr  = to_signed(a, w) - to_signed(b, w);
                ov  = (sr > smax || sr < smin) ? 1 : 0;
            end
        endcase
    endtask

    function automatic string res_tag(int op);
        case (op)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            default: return "R4";
        endcase
    endfunction

    function automatic string flag_tag(int op, bit is_ovf);
        if (op < 2) return "R7";
        if (!is_ovf) return (op == 2) ? "R3" : "R4";
        return (op == 2) ? "R5" : "R6";
    endfunction

    task automatic cmp(string req, string what, longint act, longint exp);
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run_wide(logic [WW-1:0] a, logic [WW-1:0] b, int op, string extra = "");
        longint er, ec, eo;
        @(posedge clk);
        a_w <= a; b_w <= b; op_w <= 2'(op);
        @(negedge clk);
        model(longint'(a), longint'(b), op, WW, er, ec, eo);
        n_vec++;
        cmp({res_tag(op), extra}, "result", longint'(res_w), er);
        cmp({flag_tag(op, 1'b0), extra}, "carry", longint'(cout_w), ec);
        cmp({flag_tag(op, 1'b1), extra}, "overflow", longint'(ovf_w), eo);
    endtask

    task automatic run_narrow(int a, int b, int op);
        longint er, ec, eo;
        @(posedge clk);
        a_n <= WN'(a); b_n <= WN'(b); op_n <= 2'(op);
        @(negedge clk);
        model(longint'(a), longint'(b), op, WN, er, ec, eo);
        n_vec++;
        cmp({"R9/", res_tag(op)}, "result", longint'(res_n), er);
        cmp({"R9/", flag_tag(op, 1'b0)}, "carry", longint'(cout_n), ec);
        cmp({"R9/", flag_tag(op, 1'b1)}, "overflow", longint'(ovf_n), eo);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin : stim
        a_w = '0; b_w = '0; op_w = 2'b00;
        a_n = '0; b_n = '0; op_n = 2'b00;
        // initial state: zero operands, AND -> all outputs zero (R1, R7)
        run_wide('0, '0, 0);

        // R1 / R2 bitwise patterns, R7 flags stay low
        run_wide(32'hF0F0_A5A5, 32'h0FF0_FFFF, 0);
        run_wide(32'hF0F0_A5A5, 32'h0FF0_0000, 1);
        run_wide(32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);
        run_wide(32'h8000_0000, 32'h8000_0000, 1);

        // R3 / R5 add corners
        run_wide(32'h7FFF_FFFF, 32'h0000_0001, 2);
        run_wide(32'h8000_0000, 32'h8000_0000, 2);
        run_wide(32'hFFFF_FFFF, 32'h0000_0001, 2);
        run_wide(32'h8000_0000, 32'hFFFF_FFFF, 2);
        run_wide(32'h1234_5678, 32'h0FED_CBA9, 2);

        // R4 / R6 subtract corners
        run_wide(32'h0000_0000, 32'h0000_0001, 3);
        run_wide(32'h8000_0000, 32'h0000_0001, 3);
        run_wide(32'h7FFF_FFFF, 32'hFFFF_FFFF, 3);
        run_wide(32'hDEAD_BEEF, 32'hDEAD_BEEF, 3);
        run_wide(32'h0000_0000, 32'h8000_0000, 3);

        // R8: same vector after different history gives same outputs
        run_wide(32'h8000_0000, 32'h0000_0001, 3, "/R8");
        run_wide(32'hFFFF_FFFF, 32'hFFFF_FFFF, 2, "/R8");
        run_wide(32'h8000_0000, 32'h0000_0001, 3, "/R8");

        // pseudo-random sweep over all operations
        for (int i = 0; i < 3000; i++) begin
            run_wide($urandom(), $urandom(), i % 4);
        end

        // R9: exhaustive at W = 4
        for (int op = 0; op < 4; op++) begin
            for (int a = 0; a < 16; a++) begin
                for (int b = 0; b < 16; b++) begin
                    run_narrow(a, b, op);
                end
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule